// File: doc/BRIEF.md
# Reset Sequencer with Mode Strap

This block turns a raw input clock and an asynchronous, active-low reset request into a clean reset sequence. It halves the input clock into a free-running 50% duty-cycle system clock, which keeps running through reset. It passes the request through a synchronizer and drives an active-high reset output that follows the request's length in whole system clock periods.

Around reset release it reads a shared strap pin at two points in time to choose between a compatible mode and an enhanced mode. The strap may be tied straight to the reset output, and that connection always selects enhanced mode. Once the sequence is complete it issues a one-period fetch-start strobe. A request that is held too briefly is reported as invalid. An invalid request suppresses the strobe and leaves the block in compatible mode.

All timing below counts rising edges of the system clock. "Edge T0" is the first such edge that samples the request high after it was low. "N" is the number of rising edges that sampled the request low.

Top module: `rsq_top`

## Requirements
- R1: `sys_clk` is `clk_in` divided by two: period of two input clocks, high for exactly one input clock period, and it keeps toggling while the request is low.
- R2: `rst_out`, `mode_enh`, `fetch_go` and `short_req` change only at rising edges of `sys_clk`.
- R3: `rst_out` is high for exactly N system clock periods. It rises at the second rising edge after the first low sample of the request.
- R4: `rst_out` falls at edge T0+2, two system clock periods after the request is seen released.
- R5: After a valid request, `mode_enh` becomes 1 at edge T0+4 if and only if `strap_in` read 1 at edge T0 and reads 0 at edge T0+4. Every other strap pattern gives 0, which means compatible mode.
- R6: `mode_enh` is 0 from the moment a new request passes the synchronizer until edge T0+4. After that edge it holds its latched value until the next request.
- R7: After a valid request, `fetch_go` is high for exactly one system clock period, starting at edge T0+6, and at no other time.
- R8: A request is valid only when N is at least 5. For N below 5, `short_req` is 1 from edge T0+1 until a new request passes the synchronizer, `fetch_go` stays 0 and `mode_enh` stays 0.
- R9: With `strap_in` driven by `rst_out`, every valid request ends in enhanced mode (`mode_enh` = 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Raw input clock |
| rst_req_n | input | 1 | Asynchronous reset request, active low |
| strap_in | input | 1 | Shared test/busy strap read around release |
| sys_clk | output | 1 | Half-rate 50% duty system clock |
| rst_out | output | 1 | Synchronized reset, active high |
| mode_enh | output | 1 | 1 = enhanced mode, 0 = compatible mode |
| fetch_go | output | 1 | One-period fetch-start strobe |
| short_req | output | 1 | Last request was too short to be valid |

## Verification
The bench builds the block with its defaults: two synchronizer stages, a minimum hold of 5 periods, the strap read four periods after release and the fetch strobe six periods after release. With the hold threshold at 5, request lengths of 1, 4 and 5 periods fall on both sides of the validity boundary. With a short sample gap, all four strap patterns and the feedback tie from reset output to strap complete in a few dozen cycles each. Back-to-back requests show the mode flag clearing before it is latched again.

// File: rtl/rsq_pkg.sv
`timescale 1ns/1ps
// Shared types for the reset sequencer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package rsq_pkg;
    // Operating mode chosen from the strap pattern.
    typedef enum logic {
        MODE_COMPAT = 1'b0,
        MODE_ENH    = 1'b1
    } op_mode_e;
endpackage

// File: rtl/rsq_clkdiv.sv
`timescale 1ns/1ps
// Divide-by-two clock generator.
// Produces the system clock and a tick enable that is high on the input
// edges where the system clock rises. Assumes the divider starts from a
// defined value; it has no reset because it must run through reset.
module rsq_clkdiv (
    input  logic clk_in,
    output logic sys_clk,
    output logic tick_en
);
    logic div_q;

    // Toggle once per input clock to halve the frequency.
    always_ff @(posedge clk_in) begin
        div_q <= ~div_q;
    end

    assign sys_clk = div_q;
    assign tick_en = ~div_q;
endmodule

// File: rtl/rsq_sync.sv
`timescale 1ns/1ps
// Request synchronizer and strap delay line.
// Shifts the asynchronous request through STAGES flops on each system tick.
// The strap is delayed by STAGES-1 ticks, so it lines up with the edge
// that first sampled the request. Assumes STAGES >= 2.
module rsq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_in,
    input  logic tick_en,
    input  logic req_n_async,
    input  logic strap_in,
    output logic req_pre,
    output logic req_sync,
    output logic strap_dly
);
    localparam int unsigned SDEPTH = STAGES - 1;

    logic [STAGES-1:0] req_q;
    logic [SDEPTH-1:0] strap_q;

    // Shift the raw request into the synchronizer chain.
    always_ff @(posedge clk_in) begin
        if (tick_en) begin
            req_q <= {req_q[STAGES-2:0], req_n_async};
        end
    end

    generate
        if (SDEPTH == 1) begin : g_strap_one
            // Single-stage strap capture.
            always_ff @(posedge clk_in) begin
                if (tick_en) begin
                    strap_q[0] <= strap_in;
                end
            end
        end else begin : g_strap_many
            // Multi-stage strap delay matching the request chain.
            always_ff @(posedge clk_in) begin
                if (tick_en) begin
                    strap_q <= {strap_q[SDEPTH-2:0], strap_in};
                end
            end
        end
    endgenerate

    assign req_pre   = req_q[STAGES-2];
    assign req_sync  = req_q[STAGES-1];
    assign strap_dly = strap_q[SDEPTH-1];
endmodule

// File: rtl/rsq_seq.sv
`timescale 1ns/1ps
// Reset sequence engine.
// Measures the request length, drives the reset output, latches the mode
// from the two-point strap pattern and issues the fetch strobe.
// The synchronized request acts as a synchronous active-low reset.
// Assumes STAGES-1 < SAMPLE_GAP < FETCH_GAP.
module rsq_seq #(
    parameter int unsigned STAGES     = 2,
    parameter int unsigned MIN_HOLD   = 5,
    parameter int unsigned SAMPLE_GAP = 4,
    parameter int unsigned FETCH_GAP  = 6
) (
    input  logic clk_in,
    input  logic tick_en,
    input  logic req_pre,
    input  logic req_sync,
    input  logic strap_dly,
    input  logic strap_now,
    output logic rst_out,
    output logic mode_enh,
    output logic fetch_go,
    output logic short_req
);
    import rsq_pkg::*;

    localparam int unsigned HW = $clog2(MIN_HOLD + 1);
    localparam int unsigned PW = $clog2(FETCH_GAP + 1);
    localparam logic [HW-1:0] HOLD_MAX  = HW'(MIN_HOLD);
    localparam logic [PW-1:0] P_START   = PW'(STAGES - 1);
    localparam logic [PW-1:0] P_SAMPLE  = PW'(SAMPLE_GAP - 1);
    localparam logic [PW-1:0] P_FETCH   = PW'(FETCH_GAP - 1);

    logic [HW-1:0] hold_q;
    logic [PW-1:0] phase_q;
    logic          run_q;
    logic          ok_q;
    logic          strap_hi_q;
    logic          rst_q;
    logic          fetch_q;
    logic          short_q;
    op_mode_e      mode_q;
    logic          release_seen;

    assign release_seen = req_pre & ~req_sync;

    // Count ticks on which the request was sampled low, saturating.
    always_ff @(posedge clk_in) begin
        if (tick_en) begin
            if (!req_pre) begin
                if (hold_q != HOLD_MAX) begin
                    hold_q <= hold_q + 1'b1;
                end
            end else if (req_sync) begin
                hold_q <= '0;
            end
        end
    end

    // Reset output follows the synchronized request one tick later.
    always_ff @(posedge clk_in) begin
        if (tick_en) begin
            rst_q <= ~req_sync;
        end
    end

    // Release sequence: validity, strap latch and fetch strobe.
    always_ff @(posedge clk_in) begin
        if (tick_en) begin
            fetch_q <= 1'b0;
            if (release_seen) begin
                run_q      <= 1'b1;
                phase_q    <= P_START;
                ok_q       <= (hold_q >= HOLD_MAX);
                short_q    <= (hold_q < HOLD_MAX);
                strap_hi_q <= strap_dly;
                mode_q     <= MODE_COMPAT;
            end else if (!req_sync) begin
                run_q      <= 1'b0;
                phase_q    <= '0;
                ok_q       <= 1'b0;
                short_q    <= 1'b0;
                strap_hi_q <= 1'b0;
                mode_q     <= MODE_COMPAT;
            end else if (run_q) begin
                phase_q <= phase_q + 1'b1;
                if (phase_q == P_SAMPLE) begin
                    mode_q <= (ok_q && strap_hi_q && !strap_now) ? MODE_ENH : MODE_COMPAT;
                end
                if (phase_q == P_FETCH) begin
                    fetch_q <= ok_q;
                    run_q   <= 1'b0;
                end
            end
        end
    end

    assign rst_out   = rst_q;
    assign mode_enh  = (mode_q == MODE_ENH);
    assign fetch_go  = fetch_q;
    assign short_req = short_q;
endmodule

// File: rtl/rsq_top.sv
`timescale 1ns/1ps
// Reset sequencer with mode strap: top level.
// Wires the clock divider, the request synchronizer and the sequence
// engine. Assumes clk_in is free running; all outputs are timed to the
// rising edge of sys_clk.
module rsq_top #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned MIN_HOLD    = 5,
    parameter int unsigned SAMPLE_GAP  = 4,
    parameter int unsigned FETCH_GAP   = 6
) (
    input  logic clk_in,
    input  logic rst_req_n,
    input  logic strap_in,
    output logic sys_clk,
    output logic rst_out,
    output logic mode_enh,
    output logic fetch_go,
    output logic short_req
);
    logic tick_en;
    logic req_pre;
    logic req_sync;
    logic strap_dly;

    rsq_clkdiv u_div (
        .clk_in  (clk_in),
        .sys_clk (sys_clk),
        .tick_en (tick_en)
    );

    rsq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_in      (clk_in),
        .tick_en     (tick_en),
        .req_n_async (rst_req_n),
        .strap_in    (strap_in),
        .req_pre     (req_pre),
        .req_sync    (req_sync),
        .strap_dly   (strap_dly)
    );

    rsq_seq #(
        .STAGES     (SYNC_STAGES),
        .MIN_HOLD   (MIN_HOLD),
        .SAMPLE_GAP (SAMPLE_GAP),
        .FETCH_GAP  (FETCH_GAP)
    ) u_seq (
        .clk_in    (clk_in),
        .tick_en   (tick_en),
        .req_pre   (req_pre),
        .req_sync  (req_sync),
        .strap_dly (strap_dly),
        .strap_now (strap_in),
        .rst_out   (rst_out),
        .mode_enh  (mode_enh),
        .fetch_go  (fetch_go),
        .short_req (short_req)
    );
endmodule

// File: rtl/rsq_chk.sv
`timescale 1ns/1ps
// Property checker for rsq_top, attached by bind.
// Assumes the default release gap of two system periods (four input clocks).
module rsq_chk (
    input logic clk_in,
    input logic rst_req_n,
    input logic sys_clk,
    input logic rst_out,
    input logic mode_enh,
    input logic fetch_go,
    input logic short_req
);
    logic [2:0] age_q = 3'd0;
    logic       armed;

    // Hold properties off until enough history exists for $past.
    always @(posedge clk_in) begin
        if (age_q != 3'd7) age_q <= age_q + 3'd1;
    end
    assign armed = (age_q == 3'd7);

    AST_DIV_FALL: assert property (@(posedge clk_in) disable iff (!armed)
        sys_clk |=> !sys_clk); // R1
    AST_DIV_RISE: assert property (@(posedge clk_in) disable iff (!armed)
        !sys_clk |=> sys_clk); // R1
    AST_OUT_ON_RISE: assert property (@(posedge clk_in) disable iff (!armed)
        sys_clk |=> ($stable(rst_out) && $stable(mode_enh) && $stable(fetch_go) && $stable(short_req))); // R2
    AST_RELEASE_GAP: assert property (@(posedge clk_in) disable iff (!armed)
        $fell(rst_out) |-> $past(rst_req_n, 4)); // R4
    AST_MODE_AFTER_RST: assert property (@(posedge clk_in) disable iff (!armed)
        $rose(mode_enh) |-> !rst_out); // R6
    AST_FETCH_WIDTH: assert property (@(posedge clk_in) disable iff (!armed)
        $rose(fetch_go) |=> fetch_go ##1 !fetch_go); // R7
    AST_FETCH_OUT_OF_RST: assert property (@(posedge clk_in) disable iff (!armed)
        fetch_go |-> !rst_out); // R7
    AST_SHORT_NO_FETCH: assert property (@(posedge clk_in) disable iff (!armed)
        short_req |-> (!fetch_go && !mode_enh)); // R8
endmodule

bind rsq_top rsq_chk u_chk (
    .clk_in    (clk_in),
    .rst_req_n (rst_req_n),
    .sys_clk   (sys_clk),
    .rst_out   (rst_out),
    .mode_enh  (mode_enh),
    .fetch_go  (fetch_go),
    .short_req (short_req)
);

// File: tb/sim_rsq_top.sv
`timescale 1ns/1ps
module sim_rsq_top;
    logic clk_in = 1'b0;
    logic rst_req_n;
    logic strap_drv;
    logic use_fb;
    logic strap_in;
    logic sys_clk, rst_out, mode_enh, fetch_go, short_req;

    always #5 clk_in = ~clk_in;
    assign strap_in = use_fb ? rst_out : strap_drv;

    rsq_top u0 (
        .clk_in    (clk_in),
        .rst_req_n (rst_req_n),
        .strap_in  (strap_in),
        .sys_clk   (sys_clk),
        .rst_out   (rst_out),
        .mode_enh  (mode_enh),
        .fetch_go  (fetch_go),
        .short_req (short_req)
    );

    typedef struct {
        int t0;
        int nlow;
        bit mode;
        bit shrt;
        bit fbk;
    } exp_t;

    exp_t sb_q[$];
    int   n_total = 0;
    int   n_fail  = 0;
    int   tick    = 0;
    bit   done    = 1'b0;

    // monitor state
    bit   prev_rst = 1'b0;
    int   hi_cnt   = 0;
    int   fall_t   = -1;
    int   fetch_n  = 0;
    int   fetch_t  = -1;
    bit   mode_hist [16];
    int   r2_miss  = 0;
    logic [3:0] post_s;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    endtask

    // Monitor: sample after each rising sys_clk edge and score finished items.
    initial begin
        forever begin
            @(posedge sys_clk);
            tick++;
            #3;
            post_s = {rst_out, mode_enh, fetch_go, short_req};
            if (rst_out && !prev_rst) begin
                hi_cnt  = 1;
                fetch_n = 0;
                fetch_t = -1;
            end else if (rst_out) begin
                hi_cnt++;
            end
            if (!rst_out && prev_rst) fall_t = tick;
            prev_rst = rst_out;
            if (fetch_go) begin
                fetch_n++;
                fetch_t = tick;
            end
            mode_hist[tick % 16] = mode_enh;
            if (sb_q.size() > 0 && tick == sb_q[0].t0 + 8) begin
                exp_t e;
                e = sb_q.pop_front();
                check(fall_t == e.t0 + 2, "R4", "reset fall tick", fall_t, e.t0 + 2);
                check(hi_cnt == e.nlow, "R3", "reset length", hi_cnt, e.nlow);
                check(mode_hist[(e.t0 + 3) % 16] == 1'b0, "R6", "mode before latch",
                      int'(mode_hist[(e.t0 + 3) % 16]), 0);
                check(mode_hist[(e.t0 + 4) % 16] == e.mode, e.fbk ? "R9" : "R5",
                      "mode at latch", int'(mode_hist[(e.t0 + 4) % 16]), int'(e.mode));
                check(mode_enh == e.mode, "R6", "mode held", int'(mode_enh), int'(e.mode));
                check(short_req == e.shrt, "R8", "short flag", int'(short_req), int'(e.shrt));
                if (e.shrt) begin
                    check(fetch_n == 0, "R8", "fetch count on short", fetch_n, 0);
                end else begin
                    check(fetch_n == 1, "R7", "fetch count", fetch_n, 1);
                    check(fetch_t == e.t0 + 6, "R7", "fetch tick", fetch_t, e.t0 + 6);
                end
            end
        end
    end

    // R2 probe: outputs at mid-period must equal the post-rise sample.
    initial begin
        forever begin
            @(negedge sys_clk);
            #3;
            if (tick > 2 && post_s != {rst_out, mode_enh, fetch_go, short_req}) r2_miss++;
        end
    end

    // Driver: one reset request with a strap pattern; pushes the expectation.
    task automatic run_case(input int nlow, input bit s_rel, input bit s_late, input bit fb);
        exp_t e;
        @(posedge sys_clk);
        #2;
        rst_req_n = 1'b0;
        use_fb    = 1'b0;
        repeat (nlow) @(posedge sys_clk);
        #2;
        rst_req_n = 1'b1;
        strap_drv = s_rel;
        use_fb    = fb;
        e.t0   = tick + 1;
        e.nlow = nlow;
        e.shrt = (nlow < 5);
        e.fbk  = fb;
        e.mode = !e.shrt && (fb || (s_rel && !s_late));
        sb_q.push_back(e);
        @(posedge sys_clk);
        #2;
        strap_drv = s_late;
        wait (sb_q.size() == 0);
        repeat (3) @(posedge sys_clk);
    endtask

    initial begin
        realtime ta, tb_, tc;
        rst_req_n = 1'b0;
        strap_drv = 1'b0;
        use_fb    = 1'b0;
        repeat (3) @(posedge sys_clk);
        ta = $realtime;
        @(negedge sys_clk);
        tb_ = $realtime;
        @(posedge sys_clk);
        tc = $realtime;
        check(tc - ta == 20.0, "R1", "sys_clk period during reset", int'(tc - ta), 20);
        check(tb_ - ta == 10.0, "R1", "sys_clk high time", int'(tb_ - ta), 10);
        repeat (4) @(posedge sys_clk);
        #4;
        check(rst_out == 1'b1, "R3", "reset state rst_out", int'(rst_out), 1);
        check(fetch_go == 1'b0, "R7", "reset state fetch_go", int'(fetch_go), 0);
        check(mode_enh == 1'b0, "R6", "reset state mode", int'(mode_enh), 0);
        rst_req_n = 1'b1;
        repeat (12) @(posedge sys_clk);

        run_case(8, 1'b1, 1'b0, 1'b0);   // enhanced pattern
        run_case(8, 1'b1, 1'b1, 1'b0);   // high-high: compatible, clears prior mode
        run_case(6, 1'b0, 1'b0, 1'b0);   // low-low: compatible
        run_case(5, 1'b0, 1'b1, 1'b0);   // boundary hold, low-high: compatible
        run_case(5, 1'b1, 1'b0, 1'b0);   // boundary hold, enhanced
        run_case(4, 1'b1, 1'b0, 1'b0);   // too short (R8)
        run_case(12, 1'b0, 1'b0, 1'b1);  // strap tied to reset output (R9)
        run_case(1, 1'b1, 1'b0, 1'b0);   // single-period request (R8)
        run_case(7, 1'b0, 1'b0, 1'b1);   // feedback again after a short one (R9)

        check(r2_miss == 0, "R2", "mid-period output changes", r2_miss, 0);
        done = 1'b1;
        report();
    end

    initial begin
        #1ms;
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end
endmodule